// File: doc/BRIEF.md
# Clear-on-read MAC event status register

This block holds the 16-bit event status word of one Ethernet MAC port, together with the error-mode control register that decides which events may be recorded. The receive path reports each finished packet as a one-cycle end-of-packet strobe that comes with an 8-bit error vector. The block decides whether the packet is kept, records the error types of every kept packet and sets a sticky "packet kept" flag. A transmit FIFO underflow pulse is recorded only when stop-on-underflow is enabled.

Software reads and writes both registers over a simple single-cycle register bus. Read data is combinational. The read strobe is applied at the clock edge. Reading the status word clears every event bit except the sticky packet flag, which software clears by writing a one to it. When append mode is on, the block also presents the status word of each kept packet for one cycle, so that the receive path can place it behind the packet in its FIFO.

Top module: `mac_evt_status`

## Requirements
- R1: After reset the status word reads 0x0000, the mode register reads 0x0000 and `app_vld` is 0.
- R2: The mode register sits at address 5 and is read/write. Only bits 15:8 (pass enables), bit 1 (append enable) and bit 0 (stop-on-underflow) are stored. All other bits read as 0, so writing 0xFFFF reads back as 0xFF03. The status word sits at address 4. Any other address reads 0.
- R3: At an end-of-packet strobe, error vector bit i maps to status bit 8+i and to mode pass-enable bit 8+i. If every set error bit is enabled, the packet is kept and its error bits are ORed into status 15:8. If any set error bit is not enabled, the packet is dropped.
- R4: A dropped packet changes no status bit, even when some of its other error types are enabled.
- R5: Status bit 1 (packet kept) is set for every kept packet, including an error-free one.
- R6: Status bit 0 (underflow) is set by a `tx_unf` pulse only when mode bit 0 is 1.
- R7: A status read returns the current word. At that clock edge, all bits except bit 1 are cleared. Bit 1 is unchanged by the read.
- R8: An event that arrives in the same cycle as a status read is set after the read. It is not lost.
- R9: Bit 1 is cleared only by reset or by a write to the status address with data bit 1 equal to 1. Written data has no other effect on the status word.
- R10: When mode bit 1 is 1, each kept packet raises `app_vld` for exactly one cycle, on the cycle after its strobe. `app_word` then equals {error vector, 6'b0, 1'b1, 1'b0}. Dropped packets, and packets that end with append off, produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| rx_eop | input | 1 | End-of-packet strobe from receive path |
| rx_err | input | 8 | Error types seen in the ending packet |
| tx_unf | input | 1 | Transmit FIFO underflow pulse |
| app_vld | output | 1 | Append word valid, one cycle |
| app_word | output | 16 | Status word to place after the packet |

## Verification
The assertions assume that `rx_err` is meaningful only while `rx_eop` is high, and that all inputs are held at 0 during reset, so that past values taken right after reset are defined. They also assume that read, write and event strobes last one cycle. The bench drives every input on the falling edge and raises each strobe for a single cycle. It holds all inputs at 0 from time zero through reset. It creates same-cycle collisions of a read with an event only on purpose, to exercise the no-loss rule.

// File: rtl/mac_evt_status.sv
module mac_evt_status #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter logic [AW-1:0] STAT_ADDR = 4'd4,
  parameter logic [AW-1:0] MODE_ADDR = 4'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_eop,
  input  logic [DW/2-1:0] rx_err,
  input  logic          tx_unf,
  output logic          app_vld,
  output logic [DW-1:0] app_word
);
  localparam int NE = DW / 2;
  localparam int PAD = NE - 2;
  localparam logic [DW-1:0] PKC_M  = DW'(2);
  localparam logic [DW-1:0] MODE_M = {{NE{1'b1}}, {PAD{1'b0}}, 2'b11};

  logic [DW-1:0] stat_q, mode_q;
  logic rd_stat, wr_stat, wr_mode, pkt_keep;
  logic [DW-1:0] pkt_word, set_vec, kept;

  assign rd_stat  = reg_rd && reg_addr == STAT_ADDR;
  assign wr_stat  = reg_wr && reg_addr == STAT_ADDR;
  assign wr_mode  = reg_wr && reg_addr == MODE_ADDR;
  assign pkt_keep = rx_eop && ((rx_err & ~mode_q[DW-1:NE]) == '0);
  assign pkt_word = {rx_err, {PAD{1'b0}}, 2'b10};
  assign set_vec  = {pkt_keep ? pkt_word[DW-1:1] : '0, tx_unf & mode_q[0]};

  always_comb begin
    kept = rd_stat ? (stat_q & PKC_M) : stat_q;
    if (wr_stat && reg_wdata[1]) kept = kept & ~PKC_M;
  end

  assign reg_rdata = !reg_rd ? '0 :
                     reg_addr == STAT_ADDR ? stat_q :
                     reg_addr == MODE_ADDR ? mode_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      mode_q   <= '0;
      app_vld  <= 1'b0;
      app_word <= '0;
    end else begin
      stat_q  <= kept | set_vec;
      if (wr_mode) mode_q <= reg_wdata & MODE_M;
      app_vld <= pkt_keep && mode_q[1];
      if (pkt_keep && mode_q[1]) app_word <= pkt_word;
    end
  end
endmodule

// File: rtl/mac_evt_status_chk.sv
module mac_evt_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stat,
  input logic        wr_stat,
  input logic        wdata_pkc,
  input logic        rx_eop,
  input logic [7:0]  rx_err,
  input logic        tx_unf,
  input logic [15:0] mode,
  input logic [15:0] stat,
  input logic        app_vld
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  AST_RXERR_GATED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    stat[15:8] != $past(stat[15:8]) |-> (stat[15:8] & ~$past(stat[15:8]) & ~$past(mode[15:8])) == 8'h0); // R3
  AST_MULTI_DROP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(rx_eop) && (($past(rx_err) & ~$past(mode[15:8])) != 8'h0) && !$past(rd_stat) && !$past(wr_stat)
    |-> stat[15:1] == $past(stat[15:1])); // R4
  AST_UNF_GATED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(stat[0]) |-> $past(mode[0]) && $past(tx_unf)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(rd_stat) && !$past(rx_eop) && !$past(tx_unf) |-> stat[15:8] == 8'h0 && !stat[0]); // R7
  AST_PKC_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(stat[1]) && !($past(wr_stat) && $past(wdata_pkc)) |-> stat[1]); // R9
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(rd_stat) && $past(tx_unf) && $past(mode[0]) |-> stat[0]); // R8
  AST_APP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    app_vld |-> $past(rx_eop) && $past(mode[1])); // R10
endmodule

bind mac_evt_status mac_evt_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .wr_stat(wr_stat),
  .wdata_pkc(reg_wdata[1]), .rx_eop(rx_eop), .rx_err(rx_err), .tx_unf(tx_unf),
  .mode(mode_q), .stat(stat_q), .app_vld(app_vld)
);

// File: tb/tb_mac_evt_status.sv
module tb_mac_evt_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_rd = 0, reg_wr = 0, rx_eop = 0, tx_unf = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, app_word;
  logic [7:0] rx_err = 0;
  logic app_vld;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] d;
  logic av; logic [15:0] aw;

  localparam logic [3:0] ST = 4'd4, MD = 4'd5;

  always #2 clk = ~clk;

  mac_evt_status dut (.clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_eop(rx_eop),
    .rx_err(rx_err), .tx_unf(tx_unf), .app_vld(app_vld), .app_word(app_word));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic pkt(logic [7:0] e);
    @(negedge clk); rx_eop = 1; rx_err = e;
    @(negedge clk); rx_eop = 0; rx_err = 0; av = app_vld; aw = app_word;
  endtask

  task automatic unf;
    @(negedge clk); tx_unf = 1;
    @(negedge clk); tx_unf = 0;
  endtask

  task automatic t_reset;
    rd(ST, d); chk("R1 status", d, 16'h0);
    rd(MD, d); chk("R1 mode", d, 16'h0);
    chk("R1 app_vld", {15'h0, app_vld}, 16'h0);
  endtask

  task automatic t_mode;
    wr(MD, 16'hFFFF); rd(MD, d); chk("R2 mode mask", d, 16'hFF03);
    rd(4'd9, d); chk("R2 other addr", d, 16'h0);
    wr(MD, 16'h0); rd(MD, d); chk("R2 mode clear", d, 16'h0);
  endtask

  task automatic t_pkc;
    pkt(8'h04); rd(ST, d); chk("R3 dropped packet", d, 16'h0);
    pkt(8'h00); rd(ST, d); chk("R5 clean packet", d, 16'h0002);
    rd(ST, d); chk("R7 pkc survives read", d, 16'h0002);
    wr(ST, 16'hFFFD); rd(ST, d); chk("R9 write without bit1", d, 16'h0002);
    wr(ST, 16'h0002); rd(ST, d); chk("R9 write one clears", d, 16'h0);
  endtask

  task automatic t_rxerr;
    wr(MD, 16'h0C00);
    pkt(8'h04); rd(ST, d); chk("R3 enabled error", d, 16'h0402);
    rd(ST, d); chk("R7 read cleared errors", d, 16'h0002);
    pkt(8'h0C); rd(ST, d); chk("R3 all enabled multi", d, 16'h0C02);
    wr(ST, 16'h0002);
    pkt(8'h05); rd(ST, d); chk("R4 partly enabled dropped", d, 16'h0);
    pkt(8'h0D); rd(ST, d); chk("R4 mixed dropped", d, 16'h0);
  endtask

  task automatic t_unf;
    wr(MD, 16'h0000); unf; rd(ST, d); chk("R6 unf gated off", d, 16'h0);
    wr(MD, 16'h0001); unf; rd(ST, d); chk("R6 unf enabled", d, 16'h0001);
    rd(ST, d); chk("R7 unf cleared by read", d, 16'h0);
  endtask

  task automatic t_collide;
    wr(MD, 16'h0401);
    @(negedge clk); reg_rd = 1; reg_addr = ST; tx_unf = 1; rx_eop = 1; rx_err = 8'h04;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; tx_unf = 0; rx_eop = 0; rx_err = 0;
    chk("R8 read value before events", d, 16'h0);
    rd(ST, d); chk("R8 events kept past read", d, 16'h0403);
    wr(ST, 16'h0002); rd(ST, d); chk("R8 cleanup", d, 16'h0);
  endtask

  task automatic t_append;
    wr(MD, 16'h0402);
    pkt(8'h04);
    chk("R10 pulse", {15'h0, av}, 16'h1); chk("R10 word", aw, 16'h0402);
    @(negedge clk); chk("R10 single cycle", {15'h0, app_vld}, 16'h0);
    pkt(8'h01); chk("R10 dropped no pulse", {15'h0, av}, 16'h0);
    wr(MD, 16'h0400);
    pkt(8'h00); chk("R10 append off", {15'h0, av}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_mode; t_pkc; t_rxerr; t_unf; t_collide; t_append;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule